// File: doc/BRIEF.md
# Byte-Lane Memory Access Sequencer

This block connects an execution core to a 16-bit data bus that is split into a lower and an upper byte lane. The core asks for a byte or a word, to be read or written, at any 20-bit byte address. The block drives a word-aligned bus address and one enable per lane. It moves each byte between the core's low and high data bytes and the bus lane that the address selects.

A word at an even address fits in one bus cycle. A word at an odd address straddles two bus words, so the block splits it into two cycles and runs them in sequence. The core holds `reqValid` and the request fields until the block has taken them. It then waits for the single-cycle `reqReady` strobe, which marks the end of the last bus cycle. Each bus cycle lasts exactly one clock. The bus returns read data in the same cycle that `busValid` is high.

Top module: `byte_lane_seq`

## Requirements
- R1: During and right after reset, `busValid`, `busLoEn`, `busHiEn`, `busWrite` and `reqReady` are low and `rspRdata` is zero. Both lane enables are low in any cycle without `busValid`.
- R2: A byte access at an even address runs one bus cycle with `busLoEn`=1 and `busHiEn`=0. Write data is driven on `busWdata[7:0]` and the upper lane is driven to zero.
- R3: A byte access at an odd address runs one bus cycle with `busHiEn`=1 and `busLoEn`=0. The core's `reqWdata[7:0]` is driven on `busWdata[15:8]` and the lower lane is driven to zero.
- R4: A byte read returns its byte in `rspRdata[7:0]` whichever lane carried it, with `rspRdata[15:8]` zero.
- R5: A word access at an even address runs one bus cycle with both enables high and `busWdata` equal to `reqWdata`. The low byte belongs at the lower address, on bits 7:0.
- R6: A word access at an odd address A runs two back-to-back bus cycles. The first is at word address A-1 with only `busHiEn` and carries the low byte on bits 15:8. The second is at A+1 with only `busLoEn` and carries the high byte on bits 7:0.
- R7: A word read returns the byte from the lower address in `rspRdata[7:0]` and the byte from the higher address in `rspRdata[15:8]`, for both aligned and split words.
- R8: `reqReady` is high for exactly one cycle, in the cycle after the final bus cycle, and never during a bus cycle. Counted from the cycle in which `reqValid` is first seen while idle, it rises 2 cycles later for a single-cycle access and 3 cycles later for a split access. No new request is taken before then.
- R9: The second cycle of a split word wraps modulo 2^20, so an odd word at 0xFFFFF uses bus addresses 0xFFFFE and 0x00000.
- R10: `busAddr[0]` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Core request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = 16-bit word, 0 = byte |
| reqAddr | input | 20 | Byte address |
| reqWdata | input | 16 | Write data; a byte uses bits 7:0 |
| reqReady | output | 1 | One-cycle completion strobe |
| rspRdata | output | 16 | Read result, valid with `reqReady` |
| busValid | output | 1 | A bus cycle runs this clock |
| busWrite | output | 1 | The bus cycle is a write |
| busAddr | output | 20 | Word-aligned bus address |
| busLoEn | output | 1 | Lower lane (bits 7:0) enable |
| busHiEn | output | 1 | Upper lane (bits 15:8) enable |
| busWdata | output | 16 | Bus write data |
| busRdata | input | 16 | Bus read data, same cycle |

## Verification
Suppose the sequencer state stalled, skipped or repeated a phase. The bus cycle count for that request would then be wrong, and `reqReady` would appear one cycle early or late, or twice. The bench would see this within three clocks of the request. A wrong captured address or size shows up at the very first bus cycle: the enables or the word address are wrong there. A lane swap in the read path stays hidden until a read result comes back. To catch it, each split read is followed by byte reads of the same locations, so the result can be compared byte for byte against the bench's own memory copy.

// File: rtl/blseq_pkg.sv
package blseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_DONE   = 2'd3
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // capture request fields
    logic busOn;   // a bus cycle runs now
    logic second;  // this is the second half of a split word
    logic done;    // completion strobe towards the core
  } seqCtrl_t;

endpackage

// File: rtl/blseq_ctrl.sv
module blseq_ctrl
  import blseq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     splitNeeded,
  output seqCtrl_t ctrl
);

  seqState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (reqValid) stateD = ST_FIRST;
      ST_FIRST:  stateD = splitNeeded ? ST_SECOND : ST_DONE;
      ST_SECOND: stateD = ST_DONE;
      ST_DONE:   stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    ctrl.load   = (stateQ == ST_IDLE) && reqValid;
    ctrl.busOn  = (stateQ == ST_FIRST) || (stateQ == ST_SECOND);
    ctrl.second = (stateQ == ST_SECOND);
    ctrl.done   = (stateQ == ST_DONE);
  end

endmodule

// File: rtl/blseq_dp.sv
module blseq_dp
  import blseq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtrl_t          ctrl,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic              splitNeeded,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busLoEn,
  output logic              busHiEn,
  output logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] rspRdata
);

  localparam int LANE_W = DATA_W / 2;
  localparam int WADR_W = ADDR_W - 1;

  logic              writeQ, wordQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ, rdQ;
  logic [LANE_W-1:0] loIn, hiIn, loOut, hiOut;
  logic [WADR_W-1:0] baseWord, nextWord;
  logic              oddAddr, loEnD, hiEnD;

  // Request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      writeQ <= 1'b0;
      wordQ  <= 1'b0;
      addrQ  <= '0;
      dataQ  <= '0;
    end else if (ctrl.load) begin
      writeQ <= reqWrite;
      wordQ  <= reqWord;
      addrQ  <= reqAddr;
      dataQ  <= reqWdata;
    end
  end

  assign oddAddr     = addrQ[0];
  assign splitNeeded = wordQ && oddAddr;
  assign baseWord    = addrQ[ADDR_W-1:1];
  assign nextWord    = baseWord + WADR_W'(1);
  assign loIn        = busRdata[LANE_W-1:0];
  assign hiIn        = busRdata[DATA_W-1:LANE_W];

  // Lane selection and write steering
  always_comb begin
    loEnD = 1'b0;
    hiEnD = 1'b0;
    loOut = '0;
    hiOut = '0;
    if (ctrl.second) begin
      loEnD = 1'b1;
      loOut = dataQ[DATA_W-1:LANE_W];
    end else if (wordQ && !oddAddr) begin
      loEnD = 1'b1;
      hiEnD = 1'b1;
      loOut = dataQ[LANE_W-1:0];
      hiOut = dataQ[DATA_W-1:LANE_W];
    end else if (oddAddr) begin
      hiEnD = 1'b1;
      hiOut = dataQ[LANE_W-1:0];
    end else begin
      loEnD = 1'b1;
      loOut = dataQ[LANE_W-1:0];
    end
  end

  assign busLoEn  = ctrl.busOn && loEnD;
  assign busHiEn  = ctrl.busOn && hiEnD;
  assign busWrite = ctrl.busOn && writeQ;
  assign busAddr  = ctrl.busOn ? {(ctrl.second ? nextWord : baseWord), 1'b0} : '0;
  assign busWdata = busWrite ? {hiOut, loOut} : '0;

  // Read assembly
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (ctrl.load) begin
      rdQ <= '0;
    end else if (ctrl.busOn && !writeQ) begin
      if (ctrl.second)
        rdQ[DATA_W-1:LANE_W] <= loIn;
      else if (wordQ && !oddAddr)
        rdQ <= busRdata;
      else
        rdQ[LANE_W-1:0] <= oddAddr ? hiIn : loIn;
    end
  end

  assign rspRdata = rdQ;

endmodule

// File: rtl/byte_lane_seq.sv
module byte_lane_seq
  import blseq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic [DATA_W-1:0] rspRdata,
  output logic              busValid,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busLoEn,
  output logic              busHiEn,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata
);

  seqCtrl_t ctrl;
  logic     splitNeeded;

  blseq_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .splitNeeded(splitNeeded),
    .ctrl       (ctrl)
  );

  blseq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .reqWrite   (reqWrite),
    .reqWord    (reqWord),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .busRdata   (busRdata),
    .splitNeeded(splitNeeded),
    .busWrite   (busWrite),
    .busAddr    (busAddr),
    .busLoEn    (busLoEn),
    .busHiEn    (busHiEn),
    .busWdata   (busWdata),
    .rspRdata   (rspRdata)
  );

  assign busValid = ctrl.busOn;
  assign reqReady = ctrl.done;

endmodule

// File: rtl/blseq_check.sv
module blseq_check #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busLoEn,
  input logic              busHiEn,
  input logic              reqReady
);

  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);

  AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> !busAddr[0]); // R10
  AST_QUIET_LANES: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> (!busLoEn && !busHiEn)); // R1
  AST_SOME_LANE: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> (busLoEn || busHiEn)); // R2
  AST_READY_OFF_BUS: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !busValid); // R8
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> !reqReady); // R8
  AST_SPLIT_FIRST_HI: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && $past(busValid)) |-> $past(busHiEn && !busLoEn)); // R6
  AST_SPLIT_SECOND_LO: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && $past(busValid)) |-> (busLoEn && !busHiEn)); // R6
  AST_SPLIT_NEXT_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && $past(busValid)) |-> (busAddr == ADDR_W'($past(busAddr) + WORD_STEP))); // R9

endmodule

bind byte_lane_seq blseq_check #(.ADDR_W(ADDR_W)) i_blseq_check (
  .clk     (clk),
  .rstN    (rstN),
  .busValid(busValid),
  .busAddr (busAddr),
  .busLoEn (busLoEn),
  .busHiEn (busHiEn),
  .reqReady(reqReady)
);

// File: tb/test_byte_lane_seq.sv
`timescale 1ns/1ps
module test_byte_lane_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqWord = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        reqReady, busValid, busWrite, busLoEn, busHiEn;
  logic [15:0] rspRdata, busWdata, busRdata;
  logic [19:0] busAddr;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  byte_lane_seq i_byte_lane_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWord(reqWord), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqReady(reqReady), .rspRdata(rspRdata), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .busLoEn(busLoEn),
    .busHiEn(busHiEn), .busWdata(busWdata), .busRdata(busRdata)
  );

  // Bus memory model (128 bytes, address modulo 128)
  logic [7:0] busMem [128];
  logic [7:0] refMem [128];
  assign busRdata = {busMem[{busAddr[6:1], 1'b1}], busMem[{busAddr[6:1], 1'b0}]};

  typedef struct {
    logic [19:0] addr;
    logic        lo, hi, wr;
    logic [15:0] wd;
    string       tag;
  } busExp_t;

  busExp_t expQ[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops expected bus cycles, applies writes to the bus model
  always @(negedge clk) begin
    if (rstN && busValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8", "unexpected bus cycle at", busAddr, 0);
      end else begin
        busExp_t e;
        e = expQ.pop_front();
        check(busAddr == e.addr, e.tag, "busAddr", busAddr, e.addr);
        check({busLoEn, busHiEn} == {e.lo, e.hi}, e.tag, "lane enables",
              {busLoEn, busHiEn}, {e.lo, e.hi});
        check(busWrite == e.wr, e.tag, "busWrite", busWrite, e.wr);
        if (e.wr) check(busWdata == e.wd, e.tag, "busWdata", busWdata, e.wd);
      end
      if (busWrite) begin
        if (busLoEn) busMem[{busAddr[6:1], 1'b0}] = busWdata[7:0];
        if (busHiEn) busMem[{busAddr[6:1], 1'b1}] = busWdata[15:8];
      end
    end
  end

  // Driver: computes expected bus cycles and result, then runs the request
  task automatic doReq(input bit wr, input bit word, input logic [19:0] a,
                       input logic [15:0] d, input string tag);
    busExp_t     e;
    logic [19:0] a1;
    logic [15:0] expRd;
    int          nCyc, seen;
    a1 = a + 20'd1;
    e.wr = wr; e.tag = tag;
    if (word && !a[0]) begin
      e.addr = a; e.lo = 1; e.hi = 1; e.wd = d; expQ.push_back(e); nCyc = 1;
    end else if (word) begin
      e.addr = {a[19:1], 1'b0}; e.lo = 0; e.hi = 1; e.wd = {d[7:0], 8'h00};
      expQ.push_back(e);
      e.addr = a1; e.lo = 1; e.hi = 0; e.wd = {8'h00, d[15:8]};
      expQ.push_back(e); nCyc = 2;
    end else if (a[0]) begin
      e.addr = {a[19:1], 1'b0}; e.lo = 0; e.hi = 1; e.wd = {d[7:0], 8'h00};
      expQ.push_back(e); nCyc = 1;
    end else begin
      e.addr = a; e.lo = 1; e.hi = 0; e.wd = {8'h00, d[7:0]};
      expQ.push_back(e); nCyc = 1;
    end
    expRd = word ? {refMem[a1[6:0]], refMem[a[6:0]]} : {8'h00, refMem[a[6:0]]};
    if (wr) begin
      refMem[a[6:0]] = d[7:0];
      if (word) refMem[a1[6:0]] = d[15:8];
    end
    reqValid = 1; reqWrite = wr; reqWord = word; reqAddr = a; reqWdata = d;
    seen = 0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (reqReady) begin seen = k; break; end
    end
    reqValid = 0;
    check(seen == nCyc + 1, "R8", "ready latency", seen, nCyc + 1);
    check(expQ.size() == 0, tag, "missing bus cycles", expQ.size(), 0);
    if (!wr) check(rspRdata == expRd, tag, "rspRdata", rspRdata, expRd);
    @(negedge clk);
    check(!reqReady, "R8", "ready pulse width", reqReady, 0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      busMem[i] = 8'(i * 37 + 5);
      refMem[i] = 8'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    check({busValid, busLoEn, busHiEn, busWrite, reqReady} == 5'b0, "R1",
          "outputs in reset", {busValid, busLoEn, busHiEn, busWrite, reqReady}, 0);
    rstN = 1;
    @(negedge clk);
    check(rspRdata == 16'h0, "R1", "rspRdata after reset", rspRdata, 0);
    check({busLoEn, busHiEn, reqReady} == 3'b0, "R1", "idle lanes",
          {busLoEn, busHiEn, reqReady}, 0);

    doReq(1, 1, 20'h00010, 16'hBEEF, "R5");
    doReq(0, 1, 20'h00010, 16'h0,    "R7");
    doReq(1, 0, 20'h00020, 16'hAA5C, "R2");
    doReq(1, 0, 20'h00021, 16'h55C3, "R3");
    doReq(0, 0, 20'h00020, 16'h0,    "R4");
    doReq(0, 0, 20'h00021, 16'h0,    "R4");
    doReq(0, 1, 20'h00020, 16'h0,    "R7");
    doReq(1, 1, 20'h00031, 16'h1234, "R6");
    doReq(0, 1, 20'h00031, 16'h0,    "R7");
    doReq(0, 0, 20'h00031, 16'h0,    "R4");
    doReq(0, 0, 20'h00032, 16'h0,    "R4");
    doReq(1, 1, 20'hFFFFF, 16'hC0DE, "R9");
    doReq(0, 1, 20'hFFFFF, 16'h0,    "R9");
    doReq(0, 0, 20'h00000, 16'h0,    "R9");
    for (int i = 0; i < 32; i++) begin
      logic [19:0] a;
      a = 20'(i * 32'h1357 + 32'h9A);
      doReq(i[0], i[1], a, 16'(i * 32'h2F1B + 7), a[0] && i[1] ? "R6" : "R10");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R8: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule